// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a core clock from its present divide ratio to a requested one (1, 2, 4, 6 or 8) while keeping DRAM refresh valid for the whole move. A start pulse carries a target ratio index. The sequencer reads the 3-bit code currently held in the clock-divider register and plans the move. It then issues an ordered series of single-cycle actions: clear or set the DRAM self-refresh enable, write a new divider code, and load a refresh count recomputed for the new ratio. Every divider write is followed by a wait for the PLL to relock before the next action is taken.

Moves between ratio 1 and any ratio above 2 are split into two legs through ratio 2. Inside each leg, the direction of the change decides whether the refresh count is loaded before or after the divider write. When the clock slows down while self-refresh is off, the sequencer stalls until both the old and the new refresh intervals have drained. The PLL control register sits outside the block: it is seen through `div_code_i` and written through `div_we_o`/`div_wdata_o`. The self-refresh enable and the refresh-count register are held inside the block and driven out on ports.

The sequencer's states are these:
- ST_IDLE waits for a start pulse.
- ST_LEG chooses the next leg and its kind.
- ST_CLR_SREF clears self-refresh.
- ST_LD_REFR loads the refresh count.
- ST_DRAIN is the refresh drain stall.
- ST_WR_DIV writes the divider.
- ST_LOCK is the PLL lock wait.
- ST_SET_SREF sets self-refresh.
- ST_LEG_END decides whether another leg follows.
- ST_FINISH gives the done pulse.

The transitions are these:
- ST_IDLE→ST_LEG on a legal start with a new target.
- ST_IDLE→ST_FINISH on an illegal request or an equal target.
- ST_LEG→ST_CLR_SREF for a 2→1 leg, →ST_LD_REFR for a 1→2 leg or any other upward leg, and →ST_WR_DIV for any other downward leg.
- ST_CLR_SREF→ST_WR_DIV.
- ST_WR_DIV→ST_LOCK.
- ST_LOCK→ST_LD_REFR (downward legs), →ST_SET_SREF (1→2 leg) or →ST_LEG_END (other upward legs), once the lock wait has expired.
- ST_LD_REFR→ST_DRAIN when a stall is needed. Otherwise, and from ST_DRAIN once the stall has expired, the next state is ST_WR_DIV for upward legs and ST_LEG_END for downward legs.
- ST_SET_SREF→ST_LEG_END.
- ST_LEG_END→ST_FINISH when the target is reached, else →ST_LEG.
- ST_FINISH→ST_IDLE.

Top module: `clkdiv_seq`

## Requirements
- R1: Ratio index 0,1,2,3,4 selects ratio 1,2,4,6,8. The divider codes are 3'b000 for /1, 3'b001 for /2, 3'b011 for /4, 3'b010 for /6 and 3'b100 for /8. Only these codes are ever written.
- R2: A start with target index 5..7, or with a current code outside the R1 set, makes no writes and changes no register. It yields `done_o` and `err_o` high together in one cycle.
- R3: A start whose target equals the current ratio makes no writes. It yields `done_o` with `err_o` low.
- R4: A 2→1 leg clears self-refresh first, then writes the divider code, then loads the refresh count for ratio 1.
- R5: A 1→2 leg loads the refresh count for ratio 2 first, then writes the divider code, then sets self-refresh.
- R6: A move from ratio 1 to ratio 4, 6 or 8, or from ratio 4, 6 or 8 to ratio 1, runs as a leg to ratio 2 followed by a leg from ratio 2 to the target.
- R7: Any other leg to a larger ratio loads the refresh count first and writes the divider code second.
- R8: Any other leg to a smaller ratio writes the divider code first and loads the refresh count second.
- R9: After every divider write, at least LOCK_CYC idle cycles pass before the next write, refresh load or self-refresh change.
- R10: The refresh count for ratio d is floor(CLK_HZ*7800 / (64*d*10^9)). After reset, the refresh count holds the ratio-1 value and self-refresh is off.
- R11: The stall applies to a 1→2 leg or any other leg to a smaller ratio when self-refresh is off at the moment of the refresh load. After that load, the sequencer stalls for 64*(old count + new count)*(leg's starting ratio) cycles before its next action.
- R12: `busy_o` is high from the cycle after an accepted start through the done cycle. `done_o` is a one-cycle pulse. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a new move |
| tgt_idx_i | input | 3 | Target ratio index (0..4 legal) |
| div_code_i | input | 3 | Current code in the PLL divider register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected, valid with done_o |
| div_we_o | output | 1 | Divider register write strobe |
| div_wdata_o | output | 3 | Divider code to write |
| sref_en_o | output | 1 | DRAM self-refresh enable |
| refr_we_o | output | 1 | Refresh count load strobe |
| refr_cnt_o | output | REFR_W | Refresh count register |

## Verification
The assertions take for granted that the PLL register mirrors every `div_we_o` write on `div_code_i` and is not changed from elsewhere while `busy_o` is high. They also assume the refresh-count parameters keep the drain stall inside the timer width. The stimulus keeps to these conditions: the bench's register model is the only writer of `div_code_i`, and it is forced only while the block is held in reset. Random targets are drawn from indices 0..6, so illegal targets occur among legal moves. Directed cases reset the register to /4 and to an undefined code to reach the stall and error paths.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;

    localparam int NUM_RATIOS = 5;
    localparam int IDX_W      = 3;
    localparam int CODE_W     = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEG,
        ST_CLR_SREF,
        ST_LD_REFR,
        ST_DRAIN,
        ST_WR_DIV,
        ST_LOCK,
        ST_SET_SREF,
        ST_LEG_END,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        LEG_UP_1_2,
        LEG_DN_2_1,
        LEG_UP,
        LEG_DN
    } leg_kind_e;

    // divider code for each ratio index (R1)
    function automatic logic [CODE_W-1:0] code_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 3'b000;
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [3:0] ratio_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    // refresh interval in counts of 64 core clocks for a 7.8 us period (R10)
    function automatic longint unsigned refresh_count(input longint unsigned hz,
                                                      input logic [3:0] ratio);
        longint unsigned den;
        den = 64'd64 * longint'(ratio) * 64'd1000000000;
        return (hz * 64'd7800) / den;
    endfunction

endpackage

// File: rtl/clkdiv_codec.sv
module clkdiv_codec
    import clkdiv_seq_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);
    logic [NUM_RATIOS-1:0] hit;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_hit
        assign hit[g] = (code_i == code_of(IDX_W'(g)));
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i]) idx_o = IDX_W'(i);
        end
    end

    assign valid_o = |hit;

endmodule

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= load_val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 500_000_000,
    parameter int              LOCK_CYC = 16,
    parameter int              REFR_W   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [2:0]           tgt_idx_i,
    input  logic [2:0]           div_code_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 div_we_o,
    output logic [2:0]           div_wdata_o,
    output logic                 sref_en_o,
    output logic                 refr_we_o,
    output logic [REFR_W-1:0]    refr_cnt_o
);
    localparam int TAB_N     = 1 << IDX_W;
    localparam int DRAIN_MAX = 64 * 2 * ((1 << REFR_W) - 1) * 8;
    localparam int DRAIN_W   = $clog2(DRAIN_MAX + 1);
    localparam int LOCK_W    = $clog2(LOCK_CYC + 1);
    localparam int TMR_W     = (DRAIN_W > LOCK_W) ? DRAIN_W : LOCK_W;
    localparam int SINCE_W   = $clog2(LOCK_CYC + 2) + 1;

    seq_state_e            state_q, state_d;
    leg_kind_e             kind_q, kind_nx;
    logic [IDX_W-1:0]      cur_q, fin_q, leg_from_q, leg_tgt_q, hop_tgt;
    logic                  err_q, sref_q;
    logic [REFR_W-1:0]     refr_q;
    logic [REFR_W-1:0]     rc_tab [TAB_N];
    logic [IDX_W-1:0]      cur_dec;
    logic                  cur_ok, tgt_ok;
    logic [TMR_W-1:0]      drain_n, tmr_val;
    logic                  tmr_load, tmr_zero, need_drain;
    seq_state_e            after_refr;

    // refresh count per ratio index, folded at elaboration (R10)
    for (genvar g = 0; g < TAB_N; g++) begin : g_rc
        localparam longint unsigned RC = refresh_count(CLK_HZ, ratio_of(IDX_W'(g)));
        assign rc_tab[g] = REFR_W'(RC);
    end

    clkdiv_codec u_codec (
        .code_i  (div_code_i),
        .idx_o   (cur_dec),
        .valid_o (cur_ok)
    );

    assign tgt_ok = (tgt_idx_i < IDX_W'(NUM_RATIOS));

    // leg planning: hop through ratio 2 between /1 and anything above /2 (R6)
    always_comb begin
        if ((cur_q == 3'd0 && fin_q > 3'd1) || (cur_q > 3'd1 && fin_q == 3'd0))
            hop_tgt = 3'd1;
        else
            hop_tgt = fin_q;
        if (cur_q == 3'd0 && hop_tgt == 3'd1)      kind_nx = LEG_UP_1_2;
        else if (cur_q == 3'd1 && hop_tgt == 3'd0) kind_nx = LEG_DN_2_1;
        else if (hop_tgt > cur_q)                  kind_nx = LEG_UP;
        else                                       kind_nx = LEG_DN;
    end

    // stall length after a slowing refresh load (R11)
    assign drain_n = (TMR_W'({1'b0, refr_q} + {1'b0, rc_tab[leg_tgt_q]}) *
                      TMR_W'(ratio_of(leg_from_q))) << 6;
    assign need_drain = (kind_q == LEG_UP_1_2 || kind_q == LEG_DN) && !sref_q &&
                        (drain_n != '0);
    assign after_refr = (kind_q == LEG_UP_1_2 || kind_q == LEG_UP) ? ST_WR_DIV : ST_LEG_END;

    assign tmr_load = (state_q == ST_WR_DIV) || (state_q == ST_LD_REFR && need_drain);
    assign tmr_val  = (state_q == ST_WR_DIV) ? TMR_W'(LOCK_CYC - 1) : drain_n - 1'b1;

    clkdiv_wait_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!tgt_ok || !cur_ok)     state_d = ST_FINISH;
                    else if (tgt_idx_i == cur_dec) state_d = ST_FINISH;
                    else                        state_d = ST_LEG;
                end
            end
            ST_LEG: begin
                unique case (kind_nx)
                    LEG_DN_2_1: state_d = ST_CLR_SREF;
                    LEG_DN:     state_d = ST_WR_DIV;
                    default:    state_d = ST_LD_REFR;
                endcase
            end
            ST_CLR_SREF: state_d = ST_WR_DIV;
            ST_WR_DIV:   state_d = ST_LOCK;
            ST_LOCK: begin
                if (tmr_zero) begin
                    unique case (kind_q)
                        LEG_UP_1_2: state_d = ST_SET_SREF;
                        LEG_UP:     state_d = ST_LEG_END;
                        default:    state_d = ST_LD_REFR;
                    endcase
                end
            end
            ST_LD_REFR:  state_d = need_drain ? ST_DRAIN : after_refr;
            ST_DRAIN:    if (tmr_zero) state_d = after_refr;
            ST_SET_SREF: state_d = ST_LEG_END;
            ST_LEG_END:  state_d = (cur_q == fin_q) ? ST_FINISH : ST_LEG;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            fin_q      <= '0;
            leg_from_q <= '0;
            leg_tgt_q  <= '0;
            kind_q     <= LEG_UP;
            err_q      <= 1'b0;
            sref_q     <= 1'b0;
            refr_q     <= rc_tab[0];
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        err_q <= !tgt_ok || !cur_ok;
                        cur_q <= cur_dec;
                        fin_q <= tgt_idx_i;
                    end
                end
                ST_LEG: begin
                    leg_from_q <= cur_q;
                    leg_tgt_q  <= hop_tgt;
                    kind_q     <= kind_nx;
                end
                ST_CLR_SREF: sref_q <= 1'b0;
                ST_SET_SREF: sref_q <= 1'b1;
                ST_WR_DIV:   cur_q  <= leg_tgt_q;
                ST_LD_REFR:  refr_q <= rc_tab[leg_tgt_q];
                default: ;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FINISH);
    assign err_o       = done_o && err_q;
    assign div_we_o    = (state_q == ST_WR_DIV);
    assign div_wdata_o = code_of(leg_tgt_q);
    assign refr_we_o   = (state_q == ST_LD_REFR);
    assign sref_en_o   = sref_q;
    assign refr_cnt_o  = refr_q;

    // cycles since the last divider write, saturating
    logic [SINCE_W-1:0] since_div;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  since_div <= SINCE_W'(LOCK_CYC + 1);
        else if (div_we_o)                           since_div <= '0;
        else if (since_div != SINCE_W'(LOCK_CYC + 1)) since_div <= since_div + 1'b1;
    end

    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        div_we_o |-> (div_wdata_o == 3'b000 || div_wdata_o == 3'b001 ||
                      div_wdata_o == 3'b011 || div_wdata_o == 3'b010 ||
                      div_wdata_o == 3'b100));

    a_r4_sref_off_at_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_we_o && div_wdata_o == 3'b000) |-> !sref_en_o);

    a_r9_lock_before_refr: assert property (@(posedge clk) disable iff (!rst_n)
        refr_we_o |-> (since_div >= SINCE_W'(LOCK_CYC)));

    a_r9_lock_before_div: assert property (@(posedge clk) disable iff (!rst_n)
        div_we_o |-> (since_div >= SINCE_W'(LOCK_CYC)));

    a_r9_lock_before_sref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sref_en_o) |-> (since_div > SINCE_W'(LOCK_CYC)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> (fin_q == $past(fin_q)));

endmodule

// File: tb/tb_clkdiv_seq.sv
module tb_clkdiv_seq;
    localparam int              CLK_PERIOD = 10;
    localparam longint unsigned HZ         = 100_000_000;
    localparam int              LOCK       = 16;
    localparam int              RW         = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    tgt_idx_i = '0;
    logic [2:0]    pll_q = '0;
    logic          busy_o, done_o, err_o, div_we_o, sref_en_o, refr_we_o;
    logic [2:0]    div_wdata_o;
    logic [RW-1:0] refr_cnt_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_seq #(.CLK_HZ(HZ), .LOCK_CYC(LOCK), .REFR_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_idx_i(tgt_idx_i),
        .div_code_i(pll_q), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .div_we_o(div_we_o), .div_wdata_o(div_wdata_o), .sref_en_o(sref_en_o),
        .refr_we_o(refr_we_o), .refr_cnt_o(refr_cnt_o)
    );

    // model of the PLL divider register
    always @(posedge clk) if (div_we_o) pll_q <= div_wdata_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    function automatic int bcode(int i);
        case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
    endfunction
    function automatic int bratio(int i);
        case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
    endfunction
    function automatic int rc(int i);
        longint unsigned v;
        v = (HZ * 64'd7800) / (64'd64 * longint'(bratio(i)) * 64'd1000000000);
        return int'(v);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // event log: type*16+value, type 1 = divider write, 2 = refresh load, 3 = self-refresh change
    int got[$];
    int got_t[$];
    int exp_q[$];
    int cyc = 0, last_div = -100000, lock_viol = 0, done_cnt = 0, done_cyc = 0;
    bit r_pend = 0, sref_prev = 0, err_seen = 0, busy_at_done = 0;

    always @(negedge clk) begin
        cyc++;
        if (r_pend) begin
            got.push_back(2*16 + int'(refr_cnt_o)); got_t.push_back(cyc-1);
            if ((cyc-1) - last_div < LOCK+1) lock_viol++;
            r_pend = 0;
        end
        if (rst_n && sref_en_o != sref_prev) begin
            got.push_back(3*16 + int'(sref_en_o)); got_t.push_back(cyc-1);
            if ((cyc-1) - last_div < LOCK+1) lock_viol++;
        end
        sref_prev = sref_en_o;
        if (refr_we_o) r_pend = 1;
        if (div_we_o) begin
            got.push_back(1*16 + int'(div_wdata_o)); got_t.push_back(cyc);
            if (cyc - last_div < LOCK+1) lock_viol++;
            last_div = cyc;
        end
        if (done_o) begin
            done_cnt++; done_cyc = cyc; busy_at_done = busy_o;
            if (err_o) err_seen = 1;
        end
    end

    int  exp_idx = 0, exp_refr = 0;
    bit  exp_sref = 0, cur_legal = 1;

    task automatic add_leg(int f, int t);
        if (f == 0 && t == 1) begin
            exp_q.push_back(2*16 + rc(1)); exp_q.push_back(1*16 + bcode(1));
            if (!exp_sref) exp_q.push_back(3*16 + 1);
            exp_sref = 1;
        end else if (f == 1 && t == 0) begin
            if (exp_sref) exp_q.push_back(3*16 + 0);
            exp_sref = 0;
            exp_q.push_back(1*16 + bcode(0)); exp_q.push_back(2*16 + rc(0));
        end else if (t > f) begin
            exp_q.push_back(2*16 + rc(t)); exp_q.push_back(1*16 + bcode(t));
        end else begin
            exp_q.push_back(1*16 + bcode(t)); exp_q.push_back(2*16 + rc(t));
        end
        exp_refr = rc(t);
    endtask

    function automatic string tag_of(int f, int t);
        if (t > 4 || !cur_legal) return "R2";
        if (f == t) return "R3";
        if ((f == 0 && t > 1) || (f > 1 && t == 0)) return "R6";
        if (f == 1 && t == 0) return "R4";
        if (f == 0 && t == 1) return "R5";
        if (t > f) return "R7";
        return "R8";
    endfunction

    task automatic do_reset(logic [2:0] init);
        rst_n = 0; pll_q = init;
        repeat (3) @(negedge clk);
        rst_n = 1;
        exp_sref = 0; exp_refr = rc(0); sref_prev = 0;
        cur_legal = 1;
        case (init)
            3'b000: exp_idx = 0; 3'b001: exp_idx = 1; 3'b011: exp_idx = 2;
            3'b010: exp_idx = 3; 3'b100: exp_idx = 4; default: cur_legal = 0;
        endcase
        @(negedge clk);
    endtask

    task automatic do_run(int tgt, bit inject, int tgt2);
        string tag;
        int w;
        bit legal;
        tag = tag_of(exp_idx, tgt);
        legal = (tgt < 5) && cur_legal;
        exp_q.delete(); got.delete(); got_t.delete();
        done_cnt = 0; err_seen = 0; lock_viol = 0;
        if (legal && tgt != exp_idx) begin
            if ((exp_idx == 0 && tgt > 1) || (exp_idx > 1 && tgt == 0)) begin
                add_leg(exp_idx, 1); add_leg(1, tgt);
            end else add_leg(exp_idx, tgt);
        end
        start_i = 1; tgt_idx_i = 3'(tgt);
        @(negedge clk); start_i = 0;
        if (inject) begin
            repeat (5) @(negedge clk);
            start_i = 1; tgt_idx_i = 3'(tgt2);
            @(negedge clk); start_i = 0;
        end
        w = 0;
        while (done_cnt == 0 && w < 30000) begin @(negedge clk); w++; end
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R12", "done pulses", done_cnt, 1);
        check(busy_at_done == 1 && busy_o == 0, "R12", "busy at done / after", int'(busy_at_done), 1);
        check(err_seen == !legal, tag, "error flag", int'(err_seen), int'(!legal));
        check(got.size() == exp_q.size(), tag, "event count", got.size(), exp_q.size());
        foreach (exp_q[i]) begin
            if (i < got.size())
                check(got[i] == exp_q[i], tag, $sformatf("event %0d (type*16+value)", i), got[i], exp_q[i]);
        end
        check(lock_viol == 0, "R9", "lock wait violations", lock_viol, 0);
        if (legal) exp_idx = tgt;
        if (cur_legal)
            check(int'(pll_q) == bcode(exp_idx), "R1", "divider register code", int'(pll_q), bcode(exp_idx));
        check(sref_en_o == exp_sref, tag, "self-refresh", int'(sref_en_o), int'(exp_sref));
        check(int'(refr_cnt_o) == exp_refr, "R10", "refresh count", int'(refr_cnt_o), exp_refr);
    endtask

    initial begin
        int seed;
        int gap;
        seed = $urandom(32'h5EED_0042);
        do_reset(3'b000);
        // R10: reset state
        check(busy_o == 0 && done_o == 0, "R12", "idle after reset", int'(busy_o), 0);
        check(sref_en_o == 0, "R10", "self-refresh after reset", int'(sref_en_o), 0);
        check(int'(refr_cnt_o) == rc(0), "R10", "refresh count after reset", int'(refr_cnt_o), rc(0));

        do_run(0, 0, 0);                    // R3
        do_run(1, 0, 0);                    // R5 with drain R11
        if (got_t.size() >= 2) begin
            gap = got_t[1] - got_t[0];
            check(gap >= 64*(rc(0)+rc(1))*1 + 1, "R11", "1->2 drain cycles", gap, 64*(rc(0)+rc(1)) + 1);
        end
        do_run(0, 0, 0);                    // R4
        do_run(4, 0, 0);                    // R6
        do_run(2, 0, 0);                    // R8
        do_run(3, 0, 0);                    // R7
        do_run(6, 0, 0);                    // R2 target out of range
        do_run(0, 0, 0);                    // R6 downward hop
        do_run(1, 1, 4);                    // R12 start while busy ignored
        do_run(1, 0, 0);                    // R3 same ratio again

        do_reset(3'b011);                   // R11 on a downward leg, self-refresh off
        do_run(1, 0, 0);
        if (got_t.size() >= 2) begin
            gap = done_cyc - got_t[1];
            check(gap >= 64*(rc(0)+rc(1))*4, "R11", "4->2 drain cycles", gap, 64*(rc(0)+rc(1))*4);
        end

        do_reset(3'b101);                   // R2 undefined current code
        do_run(0, 0, 0);
        check(int'(pll_q) == 5, "R2", "register untouched", int'(pll_q), 5);

        do_reset(3'b000);
        for (int k = 0; k < 25; k++) do_run(int'($urandom_range(0, 6)), 0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R12 watchdog expired: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule